// File: doc/BRIEF.md
# Interrupt Source Selection and Priority Polling

This block collects eleven interrupt requests (five general-purpose request lines and six from the serial controller and the two DMA channels) and reduces them to a single request to the processor with a 4-bit vector index. The serial receive-valid and transmit-valid requests are taken either from FIFO-level flags or from operation-done flags. A mode input picks which. That input only steers the interrupt source and has no effect on any DMA channel. The receive-error and transmit-error requests are each the OR of a group of error-condition inputs.

A machine cycle lasts `CYC_LEN` clocks. The masked flags are captured once per machine cycle, on its last clock. During the following machine cycle a scanner steps through the captured flags one source per clock, in a fixed polling order. It records the first pending high-priority source and the first pending low-priority source. When the scan ends, the winner is offered to the processor unless the in-service state blocks it. A return input, pulsed when the processor finishes a handler, releases the most recent in-service level.

Top module: `intr_sel_poll`

## Requirements
- R1: Vector indices follow the polling order: `legacy_req[0..4]` give 0 to 4, receive-valid gives 5, receive-error gives 6, transmit-valid gives 7, transmit-error gives 8, DMA channel 0 done gives 9 and DMA channel 1 done gives 10.
- R2: When `dma_mode` is 0, receive-valid follows `rx_fifo_ne` and `rx_done` is ignored. When `dma_mode` is 1, receive-valid follows `rx_done` and `rx_fifo_ne` is ignored.
- R3: When `dma_mode` is 0, transmit-valid follows `tx_fifo_nf` and `tx_done` is ignored. When `dma_mode` is 1, transmit-valid follows `tx_done` and `tx_fifo_nf` is ignored.
- R4: Any single bit of `rx_err` raises receive-error (vector 6), and any single bit of `tx_err` raises transmit-error (vector 8).
- R5: A source whose `src_en` bit is 0 is never issued. While `glob_en` is 0, no source is issued.
- R6: Flags are captured once per machine cycle of `CYC_LEN` clocks. A winner is reported as a one-clock `irq_valid` pulse carrying `irq_vec`, at most once per machine cycle.
- R7: A pending source with its `src_hi` bit set wins over every pending source whose bit is clear, whatever their polling order.
- R8: Among pending sources of the same priority level, the one with the lowest vector index wins.
- R9: While a high-priority request is in service, nothing is issued. While only a low-priority request is in service, only high-priority requests are issued.
- R10: A one-clock `svc_return` pulse clears the high in-service level if it is set, and otherwise clears the low level. When an issue happens in the same clock, the return is applied to the state held before that issue.
- R11: After reset, `irq_valid` and `irq_vec` are 0 and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| legacy_req | input | 5 | General-purpose request lines, vectors 0 to 4 |
| rx_fifo_ne | input | 1 | Receive FIFO not empty |
| rx_done | input | 1 | Receive operation done |
| tx_fifo_nf | input | 1 | Transmit FIFO not full |
| tx_done | input | 1 | Transmit operation done |
| rx_err | input | RXE_W | Receive error conditions |
| tx_err | input | TXE_W | Transmit error conditions |
| dma0_done | input | 1 | DMA channel 0 finished |
| dma1_done | input | 1 | DMA channel 1 finished |
| dma_mode | input | 1 | 0: FIFO-level flags raise valid requests; 1: done flags do |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 11 | Per-source enable, bit i is vector i |
| src_hi | input | 11 | Per-source high-priority select, bit i is vector i |
| svc_return | input | 1 | Handler finished; release one in-service level |
| irq_valid | output | 1 | One-clock request to the processor |
| irq_vec | output | 4 | Vector index of the issued source |

## Verification
A handler return and a new issue decision can fall on the same clock. This happens when a low-priority handler is being left just as the scan ends with a high-priority winner. The bench finds the phase from a previous `irq_valid` pulse, counts `CYC_LEN-1` clocks and drives `svc_return` so that it lands on the clock of the next decision. The outcome is judged afterwards. The high-priority vector must be issued, and a single further return must release the still-pending low-priority source, which shows that the return cleared the low level and not the new high one.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_SRC = 11;
  localparam int LEG_N   = 5;
  localparam int VEC_W   = 4;
  localparam int IDX_RXV = 5;
  localparam int IDX_RXE = 6;
  localparam int IDX_TXV = 7;
  localparam int IDX_TXE = 8;
  localparam int IDX_DM0 = 9;
  localparam int IDX_DM1 = 10;
endpackage

// File: rtl/intr_src_gather.sv
module intr_src_gather import intr_pkg::*; #(
  parameter int RXE_W = 3,
  parameter int TXE_W = 3
) (
  input  logic [LEG_N-1:0]   legacy_req,
  input  logic               rx_fifo_ne,
  input  logic               rx_done,
  input  logic               tx_fifo_nf,
  input  logic               tx_done,
  input  logic [RXE_W-1:0]   rx_err,
  input  logic [TXE_W-1:0]   tx_err,
  input  logic               dma0_done,
  input  logic               dma1_done,
  input  logic               dma_mode,
  input  logic               glob_en,
  input  logic [NUM_SRC-1:0] src_en,
  output logic [NUM_SRC-1:0] req
);
  logic               rxv, txv, rxe, txe;
  logic [NUM_SRC-1:0] raw;

  // mode bit only steers which flag is the valid request (R2, R3)
  always_comb begin
    rxv = dma_mode ? rx_done : rx_fifo_ne;
    txv = dma_mode ? tx_done : tx_fifo_nf;
    rxe = |rx_err;   // R4
    txe = |tx_err;
  end

  always_comb begin
    raw = '0;
    raw[LEG_N-1:0] = legacy_req;
    raw[IDX_RXV]   = rxv;
    raw[IDX_RXE]   = rxe;
    raw[IDX_TXV]   = txv;
    raw[IDX_TXE]   = txe;
    raw[IDX_DM0]   = dma0_done;
    raw[IDX_DM1]   = dma1_done;
    req = glob_en ? (raw & src_en) : '0;   // R5
  end
endmodule

// File: rtl/intr_cycle_timer.sv
module intr_cycle_timer import intr_pkg::*; #(
  parameter int CYC_LEN = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             sample_stb,
  output logic             scan_en,
  output logic             scan_first,
  output logic             scan_last,
  output logic [VEC_W-1:0] scan_idx
);
  localparam int PH_W = $clog2(CYC_LEN);

  logic [PH_W-1:0] phase_q, phase_n;

  always_comb begin
    if (phase_q == PH_W'(CYC_LEN - 1)) phase_n = '0;
    else                               phase_n = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_n;
  end

  always_comb begin
    sample_stb = (phase_q == PH_W'(CYC_LEN - 1));
    scan_en    = (phase_q < PH_W'(NUM_SRC));
    scan_first = (phase_q == '0);
    scan_last  = (phase_q == PH_W'(NUM_SRC - 1));
    scan_idx   = VEC_W'(phase_q);
  end

  assert_cycle_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_W'(CYC_LEN - 1)) |=> (phase_q == '0));
endmodule

// File: rtl/intr_poll_scan.sv
module intr_poll_scan import intr_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_stb,
  input  logic               scan_en,
  input  logic               scan_first,
  input  logic               scan_last,
  input  logic [VEC_W-1:0]   scan_idx,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] pri,
  output logic               done_stb,
  output logic               win_valid,
  output logic               win_hi,
  output logic [VEC_W-1:0]   win_vec
);
  logic [NUM_SRC-1:0] samp_q, spri_q;
  logic               hi_fnd_q, hi_fnd_n, lo_fnd_q, lo_fnd_n;
  logic [VEC_W-1:0]   hi_idx_q, hi_idx_n, lo_idx_q, lo_idx_n;
  logic               bit_on, bit_hi;

  // one capture per machine cycle (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      spri_q <= '0;
    end else if (sample_stb) begin
      samp_q <= req;
      spri_q <= pri;
    end
  end

  // sequential poll: one source per clock, first hit per level kept (R7, R8)
  always_comb begin
    bit_on   = scan_en && samp_q[scan_idx];
    bit_hi   = spri_q[scan_idx];
    hi_fnd_n = scan_first ? 1'b0 : hi_fnd_q;
    hi_idx_n = scan_first ? '0   : hi_idx_q;
    lo_fnd_n = scan_first ? 1'b0 : lo_fnd_q;
    lo_idx_n = scan_first ? '0   : lo_idx_q;
    if (bit_on) begin
      if (bit_hi) begin
        if (!hi_fnd_n) begin
          hi_fnd_n = 1'b1;
          hi_idx_n = scan_idx;
        end
      end else if (!lo_fnd_n) begin
        lo_fnd_n = 1'b1;
        lo_idx_n = scan_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_fnd_q <= 1'b0;
      hi_idx_q <= '0;
      lo_fnd_q <= 1'b0;
      lo_idx_q <= '0;
    end else if (scan_en) begin
      hi_fnd_q <= hi_fnd_n;
      hi_idx_q <= hi_idx_n;
      lo_fnd_q <= lo_fnd_n;
      lo_idx_q <= lo_idx_n;
    end
  end

  always_comb begin
    done_stb  = scan_last;
    win_valid = hi_fnd_n || lo_fnd_n;
    win_hi    = hi_fnd_n;
    win_vec   = hi_fnd_n ? hi_idx_n : lo_idx_n;
  end

  logic [NUM_SRC-1:0] lower_mask, level_mask;
  always_comb begin
    lower_mask = (NUM_SRC'(1) << win_vec) - NUM_SRC'(1);
    level_mask = win_hi ? spri_q : ~spri_q;
  end

  assert_hi_beats_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_last && win_valid && !win_hi) |-> ((samp_q & spri_q) == '0));

  assert_first_in_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_last && win_valid) |-> ((samp_q & level_mask & lower_mask) == '0));

  assert_winner_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_last && win_valid) |-> samp_q[win_vec]);
endmodule

// File: rtl/intr_svc_track.sv
module intr_svc_track import intr_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_stb,
  input  logic             win_valid,
  input  logic             win_hi,
  input  logic [VEC_W-1:0] win_vec,
  input  logic             svc_return,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec
);
  logic             svc_hi_q, svc_hi_n, svc_lo_q, svc_lo_n;
  logic             valid_q, blocked, issue;
  logic [VEC_W-1:0] vec_q, vec_n;

  // R9: block equal or lower priority than what is in service
  always_comb begin
    blocked = svc_hi_q || (svc_lo_q && !win_hi);
    issue   = done_stb && win_valid && !blocked;
  end

  // R10: return acts on the old state, then a new issue is recorded
  always_comb begin
    svc_hi_n = svc_hi_q;
    svc_lo_n = svc_lo_q;
    if (svc_return) begin
      if (svc_hi_q) svc_hi_n = 1'b0;
      else          svc_lo_n = 1'b0;
    end
    if (issue) begin
      if (win_hi) svc_hi_n = 1'b1;
      else        svc_lo_n = 1'b1;
    end
    vec_n = issue ? win_vec : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi_q <= 1'b0;
      svc_lo_q <= 1'b0;
      valid_q  <= 1'b0;
      vec_q    <= '0;
    end else begin
      svc_hi_q <= svc_hi_n;
      svc_lo_q <= svc_lo_n;
      valid_q  <= issue;
      vec_q    <= vec_n;
    end
  end

  assign irq_valid = valid_q;
  assign irq_vec   = vec_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  assert_hi_blocks_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi_q |=> !valid_q);

  assert_lo_blocks_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_lo_q && done_stb && win_valid && !win_hi) |=> !valid_q);

  assert_ret_clears_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_return && svc_hi_q) |=> !svc_hi_q);

  assert_ret_clears_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_return && !svc_hi_q && svc_lo_q) |=> !svc_lo_q);
endmodule

// File: rtl/intr_sel_poll.sv
module intr_sel_poll import intr_pkg::*; #(
  parameter int CYC_LEN = 12,
  parameter int RXE_W   = 3,
  parameter int TXE_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEG_N-1:0]   legacy_req,
  input  logic               rx_fifo_ne,
  input  logic               rx_done,
  input  logic               tx_fifo_nf,
  input  logic               tx_done,
  input  logic [RXE_W-1:0]   rx_err,
  input  logic [TXE_W-1:0]   tx_err,
  input  logic               dma0_done,
  input  logic               dma1_done,
  input  logic               dma_mode,
  input  logic               glob_en,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_hi,
  input  logic               svc_return,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vec
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_SRC-1:0] req;
  logic               sample_stb, scan_en, scan_first, scan_last;
  logic [VEC_W-1:0]   scan_idx;
  logic               done_stb, win_valid, win_hi;
  logic [VEC_W-1:0]   win_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  intr_src_gather #(.RXE_W(RXE_W), .TXE_W(TXE_W)) i_gather (
    .legacy_req(legacy_req), .rx_fifo_ne(rx_fifo_ne), .rx_done(rx_done),
    .tx_fifo_nf(tx_fifo_nf), .tx_done(tx_done), .rx_err(rx_err),
    .tx_err(tx_err), .dma0_done(dma0_done), .dma1_done(dma1_done),
    .dma_mode(dma_mode), .glob_en(glob_en), .src_en(src_en), .req(req)
  );

  intr_cycle_timer #(.CYC_LEN(CYC_LEN)) i_timer (
    .clk(clk), .rst_n(rst_int_n), .sample_stb(sample_stb), .scan_en(scan_en),
    .scan_first(scan_first), .scan_last(scan_last), .scan_idx(scan_idx)
  );

  intr_poll_scan i_scan (
    .clk(clk), .rst_n(rst_int_n), .sample_stb(sample_stb), .scan_en(scan_en),
    .scan_first(scan_first), .scan_last(scan_last), .scan_idx(scan_idx),
    .req(req), .pri(src_hi), .done_stb(done_stb), .win_valid(win_valid),
    .win_hi(win_hi), .win_vec(win_vec)
  );

  intr_svc_track i_svc (
    .clk(clk), .rst_n(rst_int_n), .done_stb(done_stb), .win_valid(win_valid),
    .win_hi(win_hi), .win_vec(win_vec), .svc_return(svc_return),
    .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk)
    (!rst_int_n) |=> !irq_valid);
endmodule

// File: tb/test_intr_sel_poll.sv
module test_intr_sel_poll;
  localparam int CYC = 12;
  localparam int RW  = 3;
  localparam int TW  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  legacy_req = '0;
  logic        rx_fifo_ne = 0, rx_done = 0, tx_fifo_nf = 0, tx_done = 0;
  logic [RW-1:0] rx_err = '0;
  logic [TW-1:0] tx_err = '0;
  logic        dma0_done = 0, dma1_done = 0, dma_mode = 0, glob_en = 1;
  logic [10:0] src_en = '1, src_hi = '0;
  logic        svc_return = 0;
  logic        irq_valid;
  logic [3:0]  irq_vec;

  int checks = 0, fails = 0;
  int exp_q[$];
  string cur_tag = "R11";
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  intr_sel_poll #(.CYC_LEN(CYC), .RXE_W(RW), .TXE_W(TW)) i_intr_sel_poll (
    .clk(clk), .rst_n(rst_n), .legacy_req(legacy_req), .rx_fifo_ne(rx_fifo_ne),
    .rx_done(rx_done), .tx_fifo_nf(tx_fifo_nf), .tx_done(tx_done),
    .rx_err(rx_err), .tx_err(tx_err), .dma0_done(dma0_done),
    .dma1_done(dma1_done), .dma_mode(dma_mode), .glob_en(glob_en),
    .src_en(src_en), .src_hi(src_hi), .svc_return(svc_return),
    .irq_valid(irq_valid), .irq_vec(irq_vec)
  );

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && irq_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected irq_vec=%0d, expected no request", cur_tag, irq_vec);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (irq_vec != e[3:0]) begin
          fails++;
          $display("FAIL %s: irq_vec=%0d expected %0d", cur_tag, irq_vec, e);
        end
      end
    end
  end

  task automatic set_src(input int idx, input bit on);
    case (idx)
      0, 1, 2, 3, 4: legacy_req[idx] = on;
      5: if (dma_mode) rx_done = on; else rx_fifo_ne = on;
      6: rx_err[0] = on;
      7: if (dma_mode) tx_done = on; else tx_fifo_nf = on;
      8: tx_err[0] = on;
      9: dma0_done = on;
      default: dma1_done = on;
    endcase
  endtask

  task automatic expect_vec(input string tag, input int v);
    int waited = 0;
    cur_tag = tag;
    exp_q.push_back(v);
    while (exp_q.size() != 0 && waited < 4 * CYC) begin
      @(posedge clk);
      waited++;
    end
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL %s: no request seen, expected irq_vec=%0d", tag, v);
      exp_q.delete();
    end
  endtask

  task automatic expect_none(input string tag);
    cur_tag = tag;
    repeat (3 * CYC) @(posedge clk);
    checks++;
  endtask

  task automatic pulse_ret();
    @(negedge clk) svc_return = 1;
    @(negedge clk) svc_return = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    legacy_req = '0; rx_fifo_ne = 0; rx_done = 0; tx_fifo_nf = 0; tx_done = 0;
    rx_err = '0; tx_err = '0; dma0_done = 0; dma1_done = 0;
    cur_tag = "idle";
    repeat (2 * CYC) @(negedge clk);
    pulse_ret();
    pulse_ret();
    repeat (CYC) @(negedge clk);
    dma_mode = 0; glob_en = 1; src_en = '1; src_hi = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (irq_valid !== 1'b0 || irq_vec !== 4'd0) begin
      fails++;
      $display("FAIL R11: valid=%b vec=%0d expected 0/0 in reset", irq_valid, irq_vec);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (irq_valid !== 1'b0 || irq_vec !== 4'd0) begin
      fails++;
      $display("FAIL R11: valid=%b vec=%0d expected 0/0 after reset", irq_valid, irq_vec);
    end
    expect_none("R11 idle after reset");

    // R1: each source alone gives its own vector
    for (int i = 0; i < 11; i++) begin
      @(negedge clk) set_src(i, 1);
      expect_vec("R1 vector order", i);
      clear_all();
    end

    // R2: receive-valid source select
    @(negedge clk) begin dma_mode = 0; rx_done = 1; end
    expect_none("R2 rx_done ignored in FIFO mode");
    clear_all();
    @(negedge clk) begin dma_mode = 1; rx_done = 1; end
    expect_vec("R2 rx_done in done mode", 5);
    clear_all();
    @(negedge clk) begin dma_mode = 1; rx_fifo_ne = 1; end
    expect_none("R2 rx_fifo_ne ignored in done mode");
    clear_all();

    // R3: transmit-valid source select
    @(negedge clk) begin dma_mode = 0; tx_done = 1; end
    expect_none("R3 tx_done ignored in FIFO mode");
    clear_all();
    @(negedge clk) begin dma_mode = 1; tx_done = 1; end
    expect_vec("R3 tx_done in done mode", 7);
    clear_all();
    @(negedge clk) begin dma_mode = 1; tx_fifo_nf = 1; end
    expect_none("R3 tx_fifo_nf ignored in done mode");
    clear_all();

    // R4: every error bit raises its error request
    for (int b = 1; b < RW; b++) begin
      @(negedge clk) rx_err[b] = 1;
      expect_vec("R4 rx error bit", 6);
      clear_all();
    end
    @(negedge clk) tx_err[TW-1] = 1;
    expect_vec("R4 tx error top bit", 8);
    clear_all();

    // R5: masking
    @(negedge clk) begin glob_en = 0; dma1_done = 1; legacy_req[0] = 1; end
    expect_none("R5 global enable off");
    clear_all();
    @(negedge clk) begin src_en[9] = 0; dma0_done = 1; end
    expect_none("R5 source enable off");
    clear_all();
    @(negedge clk) begin src_en[0] = 0; legacy_req[0] = 1; legacy_req[3] = 1; end
    expect_vec("R5 masked source skipped", 3);
    clear_all();

    // R8: same level, lowest index wins
    @(negedge clk) begin legacy_req[2] = 1; tx_fifo_nf = 1; end
    expect_vec("R8 same level order", 2);
    clear_all();
    @(negedge clk) begin dma0_done = 1; legacy_req[4] = 1; end
    expect_vec("R8 same level order", 4);
    clear_all();

    // R7: high level beats earlier low
    @(negedge clk) begin src_hi[10] = 1; legacy_req[1] = 1; dma1_done = 1; end
    expect_vec("R7 high beats low", 10);
    clear_all();

    // R9: high in service blocks another high
    @(negedge clk) begin src_hi[10] = 1; src_hi[9] = 1; dma1_done = 1; end
    expect_vec("R9 first high", 10);
    @(negedge clk) dma0_done = 1;
    expect_none("R9 high blocked by high");
    clear_all();

    // R9/R10: nesting and return order
    @(negedge clk) begin src_hi[8] = 1; legacy_req[3] = 1; end
    expect_vec("R9 low issued", 3);
    @(negedge clk) tx_err[1] = 1;
    expect_vec("R9 high preempts low", 8);
    @(negedge clk) legacy_req[1] = 1;
    expect_none("R9 low blocked while high in service");
    @(negedge clk) tx_err = '0;
    repeat (2 * CYC) @(negedge clk);
    pulse_ret();
    expect_none("R10 first return leaves low in service");
    pulse_ret();
    expect_vec("R10 second return frees low", 1);
    clear_all();

    // R10: return on the same clock as a high issue
    @(negedge clk) begin src_hi[9] = 1; legacy_req[2] = 1; end
    cur_tag = "R10 same-clock setup";
    exp_q.push_back(2);
    while (irq_valid !== 1'b1) @(negedge clk);
    exp_q.push_back(9);
    dma0_done = 1;
    repeat (CYC - 1) @(negedge clk);
    svc_return = 1;
    @(negedge clk) svc_return = 0;
    if (irq_valid !== 1'b1) begin
      checks++;
      fails++;
      $display("FAIL R10: valid=%b expected 1 on same-clock issue", irq_valid);
    end
    @(negedge clk) dma0_done = 0;
    repeat (2 * CYC) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: %0d pending expectations, expected 0", exp_q.size());
      exp_q.delete();
    end
    pulse_ret();
    expect_vec("R10 one return frees low after same-clock issue", 2);
    clear_all();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule